// File: doc/BRIEF.md
# Control Endpoint Transaction Controller

This block tracks the device side of control transfers on endpoint zero of a USB function. A protocol engine in front of it decodes the bus. It passes in one-cycle strobes for each token addressed to the function (SETUP, OUT or IN, with the token's device address and endpoint number), for each data packet that follows a SETUP or OUT token (with its byte count), and for the host acknowledgement of a data packet the device sent. For every token or packet that needs an answer, the block picks the reply: ACK, NAK, STALL, a data packet taken from the buffer, or a zero-length status packet.

Firmware drives the endpoint through a few single-cycle strobes. These load an IN packet, release a received packet, close the data stage, clear the two error flags, and write the function address. The block keeps a single packet buffer state of at most 32 bytes. It tracks whether the transfer is in its setup, data or status stage. From that stage it detects protocol errors and answers them with STALL. It raises a one-cycle interrupt event for every transfer milestone. While the function address is zero the function is in its default state and the other endpoints stay disabled. Any non-zero address moves it to the addressed state.

Top module: `ep0CtlEndpoint`

## Requirements
- R1: After reset, every flag is clear, the byte count is zero, the function address is zero, `otherEpEn` is low, `epIrq` is low and `hsCode` is 0 (no reply).
- R2: The block answers only tokens whose endpoint field is 0 and whose address equals the stored function address; other tokens give `hsCode` 0. Writing address A sets `otherEpEn` to (A != 0).
- R3: A data packet after a SETUP token is always answered with ACK (`hsCode` 1). It sets `outPktRdy`, loads `byteCount`, clears `inPktRdy`, pulses `epIrq` and puts the transfer in the setup stage.
- R4: In the setup or OUT-data stage, an OUT packet of at most 32 bytes is answered with ACK when `outPktRdy` is clear. It then sets `outPktRdy` and pulses `epIrq`. While `outPktRdy` is still set, such a packet gets NAK (`hsCode` 2).
- R5: In the setup or OUT-data stage, an OUT packet longer than 32 bytes is answered with STALL (`hsCode` 3).
- R6: An IN token in the setup or IN-data stage is answered with a data packet (`hsCode` 4) when `inPktRdy` is set and `outPktRdy` is clear. Otherwise it gets NAK. The host acknowledgement of that packet clears `inPktRdy` and pulses `epIrq`.
- R7: Data-end can close an IN data stage: it is given with or after the last IN packet and takes effect once that packet is acknowledged. An IN token after that point is answered with STALL.
- R8: Data-end closes an OUT data stage. An OUT packet after that point is answered with STALL.
- R9: In the status stage after an IN data stage, a zero-length OUT packet is answered with ACK, pulses `epIrq` and ends the transfer. A non-zero-length packet is answered with STALL.
- R10: After data-end closes an OUT data stage, or closes a setup stage that has no data, an IN token gets a zero-length packet (`hsCode` 5) once `outPktRdy` is clear. Its acknowledgement pulses `epIrq` and ends the transfer, after which IN tokens get NAK.
- R11: Every STALL reply sets `sentStall` and pulses `epIrq` in the same cycle and ends the transfer. A clear strobe resets `sentStall`.
- R12: A SETUP packet that arrives during a data or status stage sets `setupEnd` and pulses `epIrq`. A SETUP packet that arrives in the idle or setup stage leaves `setupEnd` unchanged. A clear strobe resets `setupEnd`.
- R13: `byteCount` holds the length of the last accepted packet and does not change while `outPktRdy` stays set, unless a new SETUP packet replaces it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tokValid | input | 1 | One-cycle token strobe |
| tokPid | input | 2 | Token kind: 0 SETUP, 1 OUT, 2 IN |
| tokAddr | input | 7 | Device address carried by the token |
| tokEp | input | 4 | Endpoint number carried by the token |
| pktValid | input | 1 | One-cycle strobe for a received data packet |
| pktLen | input | 7 | Byte count of the received packet |
| inSent | input | 1 | Host acknowledged the packet the device sent |
| swInRdySet | input | 1 | Firmware loaded an IN packet |
| swOutClr | input | 1 | Firmware released the received packet |
| swDataEnd | input | 1 | Firmware closes the current data stage |
| swStallClr | input | 1 | Clears `sentStall` |
| swSetupEndClr | input | 1 | Clears `setupEnd` |
| swAddrWe | input | 1 | Writes `swAddrVal` as the function address |
| swAddrVal | input | 7 | New function address |
| hsCode | output | 3 | Reply for the previous event: 0 none, 1 ACK, 2 NAK, 3 STALL, 4 data, 5 zero-length |
| outPktRdy | output | 1 | A received packet waits in the buffer |
| inPktRdy | output | 1 | An IN packet is loaded and not yet acknowledged |
| sentStall | output | 1 | A STALL was sent |
| setupEnd | output | 1 | A transfer was cut short by a new SETUP |
| byteCount | output | 7 | Length of the last accepted packet |
| epIrq | output | 1 | One-cycle endpoint interrupt event |
| otherEpEn | output | 1 | Function is addressed; other endpoints enabled |

## Verification
On every cycle, the assertions check the following. Every STALL reply comes with `sentStall` and an interrupt event. A data reply only follows an IN token made while a packet was loaded. A rise of `outPktRdy` carries an event and a legal count. The count stays put while the buffer is occupied. `otherEpEn` only rises after a non-zero address write. The stage sequences themselves can only be shown by the bench's scenarios. These are the STALL after a closed data stage, the zero-length status replies, the status-packet length rule, and the setup-end decision, which depends on the stage reached. The bench also sweeps every OUT length from 0 to 40, every status length from 0 to 8 and every address value.

// File: rtl/ep0Pkg.sv
package ep0Pkg;

  typedef enum logic [1:0] {
    TOK_SETUP = 2'd0,
    TOK_OUT   = 2'd1,
    TOK_IN    = 2'd2,
    TOK_RSVD  = 2'd3
  } tokPid_t;

  typedef enum logic [2:0] {
    HS_NONE  = 3'd0,
    HS_ACK   = 3'd1,
    HS_NAK   = 3'd2,
    HS_STALL = 3'd3,
    HS_DATA  = 3'd4,
    HS_ZLP   = 3'd5
  } hs_t;

  typedef enum logic [2:0] {
    ST_IDLE       = 3'd0,
    ST_SETUP      = 3'd1,
    ST_DIN        = 3'd2,
    ST_DOUT       = 3'd3,
    ST_STATUS_IN  = 3'd4,
    ST_STATUS_OUT = 3'd5
  } stage_t;

  typedef enum logic [1:0] {
    PEND_NONE  = 2'd0,
    PEND_SETUP = 2'd1,
    PEND_OUT   = 2'd2
  } pend_t;

  typedef enum logic [1:0] {
    FL_NONE = 2'd0,
    FL_DATA = 2'd1,
    FL_ZLP  = 2'd2
  } flight_t;

  // strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic setOutRdy;
    logic clrInRdy;
    logic setStall;
    logic setSetupEnd;
    logic irq;
    hs_t  hs;
  } ep0Strobes_t;

endpackage

// File: rtl/ep0Ctrl.sv
module ep0Ctrl
  import ep0Pkg::*;
#(
  parameter int ADDR_W  = 7,
  parameter int EP_W    = 4,
  parameter int LEN_W   = 7,
  parameter int MAX_PKT = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tokValid,
  input  logic [1:0]        tokPid,
  input  logic [ADDR_W-1:0] tokAddr,
  input  logic [EP_W-1:0]   tokEp,
  input  logic              pktValid,
  input  logic [LEN_W-1:0]  pktLen,
  input  logic              inSent,
  input  logic              swInRdySet,
  input  logic              swDataEnd,
  input  logic [ADDR_W-1:0] devAddr,
  input  logic              outPktRdy,
  input  logic              inPktRdy,
  output ep0Strobes_t       strb
);

  localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(MAX_PKT);

  stage_t  stage, stageNxt;
  pend_t   pend, pendNxt;
  flight_t flight, flightNxt;
  logic    lastIn, lastInNxt;
  logic    busEvt;
  logic    addrHit;
  logic    lenOver;
  tokPid_t pid;

  assign pid     = tokPid_t'(tokPid);
  assign addrHit = tokValid && (tokEp == '0) && (tokAddr == devAddr);
  assign lenOver = pktLen > MAX_LEN;

  always_comb begin
    strb      = '0;
    stageNxt  = stage;
    pendNxt   = pend;
    flightNxt = flight;
    lastInNxt = lastIn;
    busEvt    = 1'b0;

    if (addrHit) begin
      busEvt    = 1'b1;
      flightNxt = FL_NONE;
      pendNxt   = PEND_NONE;
      case (pid)
        TOK_SETUP: pendNxt = PEND_SETUP;
        TOK_OUT:   pendNxt = PEND_OUT;
        TOK_IN: begin
          if (stage == ST_STATUS_OUT) begin
            strb.hs = HS_STALL;
          end else if (outPktRdy) begin
            strb.hs = HS_NAK;
          end else begin
            case (stage)
              ST_SETUP, ST_DIN: begin
                if (inPktRdy) begin
                  strb.hs   = HS_DATA;
                  flightNxt = FL_DATA;
                  stageNxt  = ST_DIN;
                end else begin
                  strb.hs = HS_NAK;
                end
              end
              ST_STATUS_IN: begin
                strb.hs   = HS_ZLP;
                flightNxt = FL_ZLP;
              end
              default: strb.hs = HS_NAK;
            endcase
          end
        end
        default: ;
      endcase
    end else if (pktValid && pend != PEND_NONE) begin
      busEvt  = 1'b1;
      pendNxt = PEND_NONE;
      if (pend == PEND_SETUP) begin
        strb.hs        = HS_ACK;
        strb.setOutRdy = 1'b1;
        strb.clrInRdy  = 1'b1;
        strb.irq       = 1'b1;
        stageNxt       = ST_SETUP;
        lastInNxt      = 1'b0;
        flightNxt      = FL_NONE;
        if (stage inside {ST_DIN, ST_DOUT, ST_STATUS_IN, ST_STATUS_OUT})
          strb.setSetupEnd = 1'b1;
      end else begin
        case (stage)
          ST_STATUS_OUT: begin
            if (pktLen == '0) begin
              strb.hs  = HS_ACK;
              strb.irq = 1'b1;
              stageNxt = ST_IDLE;
            end else begin
              strb.hs = HS_STALL;
            end
          end
          ST_SETUP, ST_DOUT: begin
            if (lenOver) begin
              strb.hs = HS_STALL;
            end else if (outPktRdy) begin
              strb.hs = HS_NAK;
            end else begin
              strb.hs        = HS_ACK;
              strb.setOutRdy = 1'b1;
              strb.irq       = 1'b1;
              stageNxt       = ST_DOUT;
            end
          end
          ST_IDLE: strb.hs = HS_NAK;
          default: strb.hs = HS_STALL;
        endcase
      end
    end else if (inSent && flight != FL_NONE) begin
      busEvt    = 1'b1;
      flightNxt = FL_NONE;
      strb.irq  = 1'b1;
      if (flight == FL_DATA) begin
        strb.clrInRdy = 1'b1;
        if (lastIn) begin
          stageNxt  = ST_STATUS_OUT;
          lastInNxt = 1'b0;
        end
      end else begin
        stageNxt = ST_IDLE;
      end
    end

    if (strb.hs == HS_STALL) begin
      strb.setStall = 1'b1;
      strb.irq      = 1'b1;
      stageNxt      = ST_IDLE;
      lastInNxt     = 1'b0;
      flightNxt     = FL_NONE;
    end

    // data-end from firmware moves the stage when the bus is quiet
    if (swDataEnd && !busEvt) begin
      case (stage)
        ST_SETUP: begin
          if (swInRdySet || inPktRdy) lastInNxt = 1'b1;
          else                        stageNxt  = ST_STATUS_IN;
        end
        ST_DIN:  lastInNxt = 1'b1;
        ST_DOUT: stageNxt  = ST_STATUS_IN;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stage  <= ST_IDLE;
      pend   <= PEND_NONE;
      flight <= FL_NONE;
      lastIn <= 1'b0;
    end else begin
      stage  <= stageNxt;
      pend   <= pendNxt;
      flight <= flightNxt;
      lastIn <= lastInNxt;
    end
  end

endmodule

// File: rtl/ep0Datapath.sv
module ep0Datapath
  import ep0Pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int LEN_W  = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  ep0Strobes_t       strb,
  input  logic [LEN_W-1:0]  pktLen,
  input  logic              swInRdySet,
  input  logic              swOutClr,
  input  logic              swStallClr,
  input  logic              swSetupEndClr,
  input  logic              swAddrWe,
  input  logic [ADDR_W-1:0] swAddrVal,
  output logic [2:0]        hsCode,
  output logic              outPktRdy,
  output logic              inPktRdy,
  output logic              sentStall,
  output logic              setupEnd,
  output logic [LEN_W-1:0]  byteCount,
  output logic              epIrq,
  output logic [ADDR_W-1:0] devAddr,
  output logic              otherEpEn
);

  hs_t hsReg;

  assign hsCode    = hsReg;
  assign otherEpEn = (devAddr != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hsReg     <= HS_NONE;
      outPktRdy <= 1'b0;
      inPktRdy  <= 1'b0;
      sentStall <= 1'b0;
      setupEnd  <= 1'b0;
      byteCount <= '0;
      epIrq     <= 1'b0;
      devAddr   <= '0;
    end else begin
      hsReg <= strb.hs;
      epIrq <= strb.irq;

      if (strb.setOutRdy) begin
        outPktRdy <= 1'b1;
        byteCount <= pktLen;
      end else if (swOutClr) begin
        outPktRdy <= 1'b0;
      end

      if (swInRdySet)         inPktRdy <= 1'b1;
      else if (strb.clrInRdy) inPktRdy <= 1'b0;

      if (strb.setStall)      sentStall <= 1'b1;
      else if (swStallClr)    sentStall <= 1'b0;

      if (strb.setSetupEnd)   setupEnd <= 1'b1;
      else if (swSetupEndClr) setupEnd <= 1'b0;

      if (swAddrWe) devAddr <= swAddrVal;
    end
  end

endmodule

// File: rtl/ep0CtlEndpoint.sv
module ep0CtlEndpoint
  import ep0Pkg::*;
#(
  parameter int ADDR_W  = 7,
  parameter int EP_W    = 4,
  parameter int LEN_W   = 7,
  parameter int MAX_PKT = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tokValid,
  input  logic [1:0]        tokPid,
  input  logic [ADDR_W-1:0] tokAddr,
  input  logic [EP_W-1:0]   tokEp,
  input  logic              pktValid,
  input  logic [LEN_W-1:0]  pktLen,
  input  logic              inSent,
  input  logic              swInRdySet,
  input  logic              swOutClr,
  input  logic              swDataEnd,
  input  logic              swStallClr,
  input  logic              swSetupEndClr,
  input  logic              swAddrWe,
  input  logic [ADDR_W-1:0] swAddrVal,
  output logic [2:0]        hsCode,
  output logic              outPktRdy,
  output logic              inPktRdy,
  output logic              sentStall,
  output logic              setupEnd,
  output logic [LEN_W-1:0]  byteCount,
  output logic              epIrq,
  output logic              otherEpEn
);

  ep0Strobes_t       strb;
  logic [ADDR_W-1:0] devAddr;

  ep0Ctrl #(
    .ADDR_W(ADDR_W), .EP_W(EP_W), .LEN_W(LEN_W), .MAX_PKT(MAX_PKT)
  ) uCtrl (
    .clk(clk), .rstN(rstN),
    .tokValid(tokValid), .tokPid(tokPid), .tokAddr(tokAddr), .tokEp(tokEp),
    .pktValid(pktValid), .pktLen(pktLen), .inSent(inSent),
    .swInRdySet(swInRdySet), .swDataEnd(swDataEnd),
    .devAddr(devAddr), .outPktRdy(outPktRdy), .inPktRdy(inPktRdy),
    .strb(strb)
  );

  ep0Datapath #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W)
  ) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .pktLen(pktLen),
    .swInRdySet(swInRdySet), .swOutClr(swOutClr),
    .swStallClr(swStallClr), .swSetupEndClr(swSetupEndClr),
    .swAddrWe(swAddrWe), .swAddrVal(swAddrVal),
    .hsCode(hsCode), .outPktRdy(outPktRdy), .inPktRdy(inPktRdy),
    .sentStall(sentStall), .setupEnd(setupEnd), .byteCount(byteCount),
    .epIrq(epIrq), .devAddr(devAddr), .otherEpEn(otherEpEn)
  );

endmodule

// File: rtl/ep0CtlChecker.sv
module ep0CtlChecker #(
  parameter int ADDR_W  = 7,
  parameter int LEN_W   = 7,
  parameter int MAX_PKT = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              tokValid,
  input logic [1:0]        tokPid,
  input logic              pktValid,
  input logic              swAddrWe,
  input logic [ADDR_W-1:0] swAddrVal,
  input logic [2:0]        hsCode,
  input logic              outPktRdy,
  input logic              inPktRdy,
  input logic              sentStall,
  input logic              setupEnd,
  input logic [LEN_W-1:0]  byteCount,
  input logic              epIrq,
  input logic              otherEpEn
);

  localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(MAX_PKT);

  assert_stall_flag_R11: assert property (@(posedge clk) disable iff (!rstN)
    hsCode == 3'd3 |-> sentStall && epIrq);

  assert_data_after_in_R6: assert property (@(posedge clk) disable iff (!rstN)
    hsCode == 3'd4 |-> $past(tokValid) && $past(tokPid) == 2'd2 && $past(inPktRdy));

  assert_out_event_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outPktRdy) |-> epIrq && byteCount <= MAX_LEN);

  assert_count_hold_R13: assert property (@(posedge clk) disable iff (!rstN)
    $past(outPktRdy) && outPktRdy && !$past(pktValid) |-> $stable(byteCount));

  assert_addr_enable_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(otherEpEn) |-> $past(swAddrWe) && $past(swAddrVal) != '0);

  assert_setup_end_R12: assert property (@(posedge clk) disable iff (!rstN)
    $rose(setupEnd) |-> epIrq && outPktRdy && hsCode == 3'd1);

endmodule

bind ep0CtlEndpoint ep0CtlChecker #(
  .ADDR_W(ADDR_W), .LEN_W(LEN_W), .MAX_PKT(MAX_PKT)
) uChecker (
  .clk(clk), .rstN(rstN), .tokValid(tokValid), .tokPid(tokPid),
  .pktValid(pktValid), .swAddrWe(swAddrWe), .swAddrVal(swAddrVal),
  .hsCode(hsCode), .outPktRdy(outPktRdy), .inPktRdy(inPktRdy),
  .sentStall(sentStall), .setupEnd(setupEnd), .byteCount(byteCount),
  .epIrq(epIrq), .otherEpEn(otherEpEn)
);

// File: tb/tb_ep0CtlEndpoint.sv
module tb_ep0CtlEndpoint;

  localparam int CLK_PERIOD = 10;
  localparam int MAXP = 32;

  localparam int P_SETUP = 0, P_OUT = 1, P_IN = 2;
  localparam int H_NONE = 0, H_ACK = 1, H_NAK = 2, H_STALL = 3, H_DATA = 4, H_ZLP = 5;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tokValid = 1'b0;
  logic [1:0] tokPid = '0;
  logic [6:0] tokAddr = '0;
  logic [3:0] tokEp = '0;
  logic       pktValid = 1'b0;
  logic [6:0] pktLen = '0;
  logic       inSent = 1'b0;
  logic       swInRdySet = 1'b0;
  logic       swOutClr = 1'b0;
  logic       swDataEnd = 1'b0;
  logic       swStallClr = 1'b0;
  logic       swSetupEndClr = 1'b0;
  logic       swAddrWe = 1'b0;
  logic [6:0] swAddrVal = '0;
  logic [2:0] hsCode;
  logic       outPktRdy, inPktRdy, sentStall, setupEnd, epIrq, otherEpEn;
  logic [6:0] byteCount;

  int checks = 0;
  int errors = 0;
  int curAddr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ep0CtlEndpoint dut (
    .clk(clk), .rstN(rstN), .tokValid(tokValid), .tokPid(tokPid),
    .tokAddr(tokAddr), .tokEp(tokEp), .pktValid(pktValid), .pktLen(pktLen),
    .inSent(inSent), .swInRdySet(swInRdySet), .swOutClr(swOutClr),
    .swDataEnd(swDataEnd), .swStallClr(swStallClr), .swSetupEndClr(swSetupEndClr),
    .swAddrWe(swAddrWe), .swAddrVal(swAddrVal), .hsCode(hsCode),
    .outPktRdy(outPktRdy), .inPktRdy(inPktRdy), .sentStall(sentStall),
    .setupEnd(setupEnd), .byteCount(byteCount), .epIrq(epIrq), .otherEpEn(otherEpEn)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tok(input int pid, input int addr, input int ep);
    @(negedge clk);
    tokValid = 1'b1; tokPid = 2'(pid); tokAddr = 7'(addr); tokEp = 4'(ep);
    @(negedge clk);
    tokValid = 1'b0;
  endtask

  task automatic pkt(input int len);
    @(negedge clk);
    pktValid = 1'b1; pktLen = 7'(len);
    @(negedge clk);
    pktValid = 1'b0;
  endtask

  task automatic hostAck();
    @(negedge clk);
    inSent = 1'b1;
    @(negedge clk);
    inSent = 1'b0;
  endtask

  task automatic sw(input bit inRdy, input bit outClr, input bit dataEnd,
                    input bit stallClr, input bit setupClr);
    @(negedge clk);
    swInRdySet = inRdy; swOutClr = outClr; swDataEnd = dataEnd;
    swStallClr = stallClr; swSetupEndClr = setupClr;
    @(negedge clk);
    swInRdySet = 1'b0; swOutClr = 1'b0; swDataEnd = 1'b0;
    swStallClr = 1'b0; swSetupEndClr = 1'b0;
  endtask

  task automatic setAddr(input int a);
    @(negedge clk);
    swAddrWe = 1'b1; swAddrVal = 7'(a);
    @(negedge clk);
    swAddrWe = 1'b0;
  endtask

  task automatic setupPkt();
    tok(P_SETUP, curAddr, 0);
    pkt(8);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1 actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 hsCode", int'(hsCode), H_NONE);
    chk("R1 outPktRdy", int'(outPktRdy), 0);
    chk("R1 inPktRdy", int'(inPktRdy), 0);
    chk("R1 sentStall", int'(sentStall), 0);
    chk("R1 setupEnd", int'(setupEnd), 0);
    chk("R1 byteCount", int'(byteCount), 0);
    chk("R1 epIrq", int'(epIrq), 0);
    chk("R1 otherEpEn", int'(otherEpEn), 0);

    // R2 address sweep
    for (int a = 0; a < 128; a++) begin
      setAddr(a);
      chk("R2 otherEpEn", int'(otherEpEn), (a != 0) ? 1 : 0);
    end
    setAddr(0);
    curAddr = 0;
    tok(P_IN, 5, 0);
    chk("R2 wrong address", int'(hsCode), H_NONE);
    tok(P_IN, 0, 3);
    chk("R2 other endpoint", int'(hsCode), H_NONE);

    // R3 setup packet
    setupPkt();
    chk("R3 ack", int'(hsCode), H_ACK);
    chk("R3 outPktRdy", int'(outPktRdy), 1);
    chk("R3 byteCount", int'(byteCount), 8);
    chk("R3 irq", int'(epIrq), 1);
    chk("R12 no setupEnd from idle", int'(setupEnd), 0);

    // R6 IN data stage
    tok(P_IN, curAddr, 0);
    chk("R6 nak while out pending", int'(hsCode), H_NAK);
    sw(0, 1, 0, 0, 0);
    tok(P_IN, curAddr, 0);
    chk("R6 nak when not loaded", int'(hsCode), H_NAK);
    sw(1, 0, 0, 0, 0);
    chk("R6 inPktRdy set", int'(inPktRdy), 1);
    tok(P_IN, curAddr, 0);
    chk("R6 data", int'(hsCode), H_DATA);
    hostAck();
    chk("R6 inPktRdy cleared", int'(inPktRdy), 0);
    chk("R6 irq", int'(epIrq), 1);
    sw(1, 0, 1, 0, 0);
    tok(P_IN, curAddr, 0);
    chk("R7 last data", int'(hsCode), H_DATA);
    hostAck();
    chk("R7 last ack irq", int'(epIrq), 1);
    tok(P_IN, curAddr, 0);
    chk("R7 extra IN stalls", int'(hsCode), H_STALL);
    chk("R11 sentStall", int'(sentStall), 1);
    chk("R11 irq", int'(epIrq), 1);
    sw(0, 0, 0, 1, 0);
    chk("R11 clear", int'(sentStall), 0);

    // R12 setup end
    setupPkt();
    chk("R12 setup in idle", int'(setupEnd), 0);
    sw(0, 1, 0, 0, 0);
    sw(1, 0, 0, 0, 0);
    tok(P_IN, curAddr, 0);
    chk("R12 data stage entered", int'(hsCode), H_DATA);
    setupPkt();
    chk("R12 setupEnd set", int'(setupEnd), 1);
    chk("R12 irq", int'(epIrq), 1);
    chk("R3 setup clears inPktRdy", int'(inPktRdy), 0);
    sw(0, 0, 0, 0, 1);
    chk("R12 clear", int'(setupEnd), 0);
    setupPkt();
    chk("R12 setup in setup stage", int'(setupEnd), 0);

    // R9 status OUT length sweep
    for (int len = 0; len <= 8; len++) begin
      sw(0, 0, 0, 1, 1);
      setupPkt();
      sw(0, 1, 0, 0, 0);
      sw(1, 0, 1, 0, 0);
      tok(P_IN, curAddr, 0);
      hostAck();
      tok(P_OUT, curAddr, 0);
      pkt(len);
      chk("R9 status reply", int'(hsCode), (len == 0) ? H_ACK : H_STALL);
      chk("R9 status irq", int'(epIrq), 1);
      chk("R11 stall flag", int'(sentStall), (len == 0) ? 0 : 1);
    end
    tok(P_IN, curAddr, 0);
    chk("R9 transfer ended", int'(hsCode), H_NAK);

    // R4 R5 OUT length sweep
    for (int len = 0; len <= 40; len++) begin
      sw(0, 0, 0, 1, 1);
      setupPkt();
      sw(0, 1, 0, 0, 0);
      tok(P_OUT, curAddr, 0);
      pkt(len);
      if (len <= MAXP) begin
        chk("R4 ack", int'(hsCode), H_ACK);
        chk("R4 outPktRdy", int'(outPktRdy), 1);
        chk("R13 byteCount", int'(byteCount), len);
        chk("R4 irq", int'(epIrq), 1);
      end else begin
        chk("R5 stall", int'(hsCode), H_STALL);
        chk("R5 sentStall", int'(sentStall), 1);
        chk("R5 outPktRdy", int'(outPktRdy), 0);
      end
    end

    // R4 single buffer, R13 hold, R8 protocol error
    sw(0, 0, 0, 1, 1);
    setupPkt();
    sw(0, 1, 0, 0, 0);
    tok(P_OUT, curAddr, 0);
    pkt(4);
    chk("R4 first ack", int'(hsCode), H_ACK);
    tok(P_OUT, curAddr, 0);
    pkt(7);
    chk("R4 buffer full nak", int'(hsCode), H_NAK);
    chk("R13 count held", int'(byteCount), 4);
    chk("R4 still pending", int'(outPktRdy), 1);
    sw(0, 1, 0, 0, 0);
    tok(P_OUT, curAddr, 0);
    pkt(5);
    chk("R4 second ack", int'(hsCode), H_ACK);
    chk("R13 count new", int'(byteCount), 5);
    sw(0, 1, 1, 0, 0);
    tok(P_OUT, curAddr, 0);
    pkt(0);
    chk("R8 extra OUT stalls", int'(hsCode), H_STALL);

    // R10 status IN after OUT data
    sw(0, 0, 0, 1, 0);
    setupPkt();
    sw(0, 1, 0, 0, 0);
    tok(P_OUT, curAddr, 0);
    pkt(6);
    tok(P_IN, curAddr, 0);
    chk("R10 nak before data-end", int'(hsCode), H_NAK);
    sw(0, 1, 1, 0, 0);
    tok(P_IN, curAddr, 0);
    chk("R10 zlp", int'(hsCode), H_ZLP);
    hostAck();
    chk("R10 irq", int'(epIrq), 1);
    tok(P_IN, curAddr, 0);
    chk("R10 idle after status", int'(hsCode), H_NAK);

    // R10 no-data request
    setupPkt();
    sw(0, 1, 1, 0, 0);
    tok(P_IN, curAddr, 0);
    chk("R10 no-data zlp", int'(hsCode), H_ZLP);
    hostAck();
    chk("R10 no-data irq", int'(epIrq), 1);

    // R2 addressed state
    setAddr(9);
    curAddr = 9;
    chk("R2 addressed", int'(otherEpEn), 1);
    tok(P_IN, 0, 0);
    chk("R2 old address ignored", int'(hsCode), H_NONE);
    setupPkt();
    chk("R2 new address ack", int'(hsCode), H_ACK);
    tok(P_IN, 9, 1);
    chk("R2 nonzero endpoint ignored", int'(hsCode), H_NONE);

    summary();
    $finish;
  end

endmodule